// File: doc/BRIEF.md
# Password Unlock Command Sequencer

This block sits on the host side of a parallel NOR-style flash bus. It presents a 64-bit password to the device as four 16-bit pieces. The device accepts the password one piece at a time, and each piece needs a complete write sequence of its own. That sequence is two unlock writes, a command write, and then the piece itself at an address whose two low bits select the piece. After the last write of each piece, the block does one read cycle. A low byte of FFh on that read means the device's password mode is locked, and the block latches this on its `locked` output.

The block drives the address, data, chip-enable, write-enable and output-enable lines. Between one piece and the next it holds chip-enable high for a minimum gap of two microseconds. The gap length in clocks is computed from the `CLK_HZ` parameter, rounded up. A one-cycle `start` pulse launches the whole four-piece transfer. `busy` stays high while the transfer runs, and `done` pulses for one clock after the gap that follows the fourth piece.

The controller is a single state machine with these states:
- IDLE waits for `start`.
- SETUP presents address and data with write-enable high.
- WE_LO holds write-enable low.
- WE_HI raises write-enable while address and data stay unchanged.
- READ performs the status read.
- GAP times the pause between pieces.
- DONE raises the completion pulse.

The transitions are:
- IDLE→SETUP on `start`.
- SETUP→WE_LO always.
- WE_LO→WE_HI when the low time expires.
- WE_HI→SETUP for the next write of a piece, or WE_HI→READ after the fourth write.
- READ→GAP when the read time expires.
- GAP→SETUP for the next piece, or GAP→DONE after the fourth piece.
- DONE→IDLE always.

Top module: `pwd_unlock_seq`

## Requirements
- R1: During and after reset, before any start, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are high. `busy`, `done`, `locked` and `flash_dq_oe` are low.
- R2: Every piece is sent as four writes in this order:
  - data 00AAh to address 555h;
  - data 0055h to address 2AAh;
  - data {8'h00, CMD_CODE} to address 555h;
  - the piece's 16-bit value to address k.
- R3: Pieces are sent in the order k = 0, 1, 2, 3. Piece k is `password[16k+15:16k]` and is written to address k, so address bits 1:0 equal k.
- R4: Each write has one setup clock with `flash_we_n` high, then `flash_we_n` low for exactly WE_LOW_CLKS clocks, then one clock with `flash_we_n` high. Address, data, `flash_dq_oe`=1 and `flash_ce_n`=0 hold steady from the setup clock through the clock after the rising edge.
- R5: After the fourth write of each piece, `flash_oe_n` is low for exactly RD_CLKS clocks. During this read `flash_ce_n` is low, `flash_dq_oe` is 0 and the address is k. `flash_we_n` and `flash_oe_n` are never low together.
- R6: `locked` is set when the value read in any status read has `flash_dq_in[7:0]` = FFh. The upper byte has no effect on this. A locked result does not cut the transfer short. `locked` holds after `done` and is cleared when the next transfer starts.
- R7: After each piece's read, `flash_ce_n` stays high for exactly ceil(CLK_HZ·2/1,000,000) clocks before the next piece begins, or before `done`.
- R8: `done` is high for exactly one clock, after the fourth gap. `busy` is high from the clock after `start` up to, but not including, that clock. `busy` lasts 4·(4·(WE_LOW_CLKS+2)+RD_CLKS+gap) clocks.
- R9: `start` has no effect while a transfer is in progress. Exactly sixteen writes and one `done` result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock request to send the password |
| password | input | 64 | Password; piece k is bits 16k+15:16k |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| locked | output | 1 | A status read returned FFh in its low byte |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_out | output | 16 | Data driven to the flash |
| flash_dq_oe | output | 1 | Host drives the data bus when high |
| flash_dq_in | input | 16 | Data returned by the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the block with these parameters:

| Parameter | Value |
|---|---|
| CLK_HZ | 1,700,000 |
| WE_LOW_CLKS | 2 |
| RD_CLKS | 2 |
| ADDR_W | 12 |
| CMD_CODE | C3h |

With CLK_HZ at 1,700,000 the microsecond gap works out to 3.4 clocks, so the round-up to 4 clocks is exercised. A whole transfer takes only 88 busy clocks, which makes a sweep of many password patterns cheap. The model flash answers each status read with a value chosen per piece. This covers these cases:
- full-ones and upper-byte-only responses;
- a lock reported on a single middle piece;
- a restart after a locked result;
- a start pulse that arrives in the middle of a transfer.

// File: rtl/pwd_seq_pkg.sv
package pwd_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_WE_LO,
        S_WE_HI,
        S_READ,
        S_GAP,
        S_DONE
    } seq_state_t;

    localparam int          PIECES       = 4;
    localparam int          PIECE_W      = 16;
    localparam int          STEPS        = 4;
    localparam logic [11:0] UNLOCK_ADDR1 = 12'h555;
    localparam logic [11:0] UNLOCK_ADDR2 = 12'h2AA;
    localparam logic [7:0]  UNLOCK_DATA1 = 8'hAA;
    localparam logic [7:0]  UNLOCK_DATA2 = 8'h55;
    localparam logic [7:0]  LOCK_REPLY   = 8'hFF;

    // Clocks needed to cover two microseconds, rounded up.
    function automatic int gap_cycles(longint hz);
        return int'((hz * 64'd2 + 64'd999_999) / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/pwd_seq_timer.sv
module pwd_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pwd_seq_cycle_gen.sv
module pwd_seq_cycle_gen
    import pwd_seq_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter logic [7:0] CMD_CODE = 8'h38
) (
    input  logic [1:0]                 step,
    input  logic [1:0]                 piece,
    input  logic [PIECES*PIECE_W-1:0]  password,
    output logic [ADDR_W-1:0]          addr,
    output logic [PIECE_W-1:0]         data
);
    logic [PIECE_W-1:0] slice [PIECES];

    for (genvar g = 0; g < PIECES; g++) begin : g_slice
        assign slice[g] = password[g*PIECE_W +: PIECE_W];
    end

    always_comb begin
        unique case (step)
            2'd0: begin
                addr = ADDR_W'(UNLOCK_ADDR1);
                data = {8'h00, UNLOCK_DATA1};
            end
            2'd1: begin
                addr = ADDR_W'(UNLOCK_ADDR2);
                data = {8'h00, UNLOCK_DATA2};
            end
            2'd2: begin
                addr = ADDR_W'(UNLOCK_ADDR1);
                data = {8'h00, CMD_CODE};
            end
            default: begin
                addr = ADDR_W'(piece);
                data = slice[piece];
            end
        endcase
    end
endmodule

// File: rtl/pwd_unlock_seq.sv
module pwd_unlock_seq
    import pwd_seq_pkg::*;
#(
    parameter longint     CLK_HZ      = 50_000_000,
    parameter int         ADDR_W      = 16,
    parameter int         WE_LOW_CLKS = 3,
    parameter int         RD_CLKS     = 2,
    parameter logic [7:0] CMD_CODE    = 8'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       password,
    output logic              busy,
    output logic              done,
    output logic              locked,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [15:0]       flash_dq_out,
    output logic              flash_dq_oe,
    input  logic [15:0]       flash_dq_in,
    output logic              flash_ce_n,
    output logic              flash_we_n,
    output logic              flash_oe_n
);
    localparam int GAP_CLKS  = gap_cycles(CLK_HZ);
    localparam int MAX_WAIT  = (GAP_CLKS > WE_LOW_CLKS)
                             ? ((GAP_CLKS > RD_CLKS) ? GAP_CLKS : RD_CLKS)
                             : ((WE_LOW_CLKS > RD_CLKS) ? WE_LOW_CLKS : RD_CLKS);
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] WE_VAL  = CNT_W'(WE_LOW_CLKS - 1);
    localparam logic [CNT_W-1:0] RD_VAL  = CNT_W'(RD_CLKS - 1);
    localparam logic [CNT_W-1:0] GAP_VAL = CNT_W'(GAP_CLKS - 1);
    localparam logic [1:0] LAST_STEP  = 2'(STEPS - 1);
    localparam logic [1:0] LAST_PIECE = 2'(PIECES - 1);

    seq_state_t        state, state_d;
    logic [1:0]        step, step_d, piece, piece_d;
    logic              locked_q, locked_d;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] gen_addr;
    logic [15:0]       gen_data;

    pwd_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pwd_seq_cycle_gen #(.ADDR_W(ADDR_W), .CMD_CODE(CMD_CODE)) u_gen (
        .step     (step),
        .piece    (piece),
        .password (password),
        .addr     (gen_addr),
        .data     (gen_data)
    );

    // Next-state logic
    always_comb begin
        state_d  = state;
        step_d   = step;
        piece_d  = piece;
        locked_d = locked_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_d  = S_SETUP;
                    step_d   = '0;
                    piece_d  = '0;
                    locked_d = 1'b0;
                end
            end
            S_SETUP: begin
                state_d  = S_WE_LO;
                tmr_load = 1'b1;
                tmr_val  = WE_VAL;
            end
            S_WE_LO: begin
                if (tmr_expired) state_d = S_WE_HI;
            end
            S_WE_HI: begin
                if (step == LAST_STEP) begin
                    state_d  = S_READ;
                    tmr_load = 1'b1;
                    tmr_val  = RD_VAL;
                end else begin
                    step_d  = step + 2'd1;
                    state_d = S_SETUP;
                end
            end
            S_READ: begin
                if (tmr_expired) begin
                    if (flash_dq_in[7:0] == LOCK_REPLY) locked_d = 1'b1;
                    state_d  = S_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_VAL;
                end
            end
            S_GAP: begin
                if (tmr_expired) begin
                    if (piece == LAST_PIECE) begin
                        state_d = S_DONE;
                    end else begin
                        piece_d = piece + 2'd1;
                        step_d  = '0;
                        state_d = S_SETUP;
                    end
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            step     <= '0;
            piece    <= '0;
            locked_q <= 1'b0;
        end else begin
            state    <= state_d;
            step     <= step_d;
            piece    <= piece_d;
            locked_q <= locked_d;
        end
    end

    // Outputs
    always_comb begin
        flash_ce_n   = 1'b1;
        flash_we_n   = 1'b1;
        flash_oe_n   = 1'b1;
        flash_dq_oe  = 1'b0;
        flash_addr   = '0;
        flash_dq_out = '0;
        busy         = 1'b1;
        done         = 1'b0;
        unique case (state)
            S_IDLE: busy = 1'b0;
            S_SETUP, S_WE_LO, S_WE_HI: begin
                flash_ce_n   = 1'b0;
                flash_dq_oe  = 1'b1;
                flash_addr   = gen_addr;
                flash_dq_out = gen_data;
                flash_we_n   = (state != S_WE_LO);
            end
            S_READ: begin
                flash_ce_n = 1'b0;
                flash_oe_n = 1'b0;
                flash_addr = ADDR_W'(piece);
            end
            S_GAP: ;
            S_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign locked = locked_q;
endmodule

// File: rtl/pwd_seq_checker.sv
module pwd_seq_checker
    import pwd_seq_pkg::*;
#(
    parameter longint CLK_HZ      = 50_000_000,
    parameter int     ADDR_W      = 16,
    parameter int     WE_LOW_CLKS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              locked,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [15:0]       flash_dq_out,
    input logic              flash_dq_oe,
    input logic              flash_ce_n,
    input logic              flash_we_n,
    input logic              flash_oe_n
);
    localparam int GAP_CLKS = gap_cycles(CLK_HZ);

    logic [15:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= (busy && flash_ce_n) ? hi_cnt + 16'd1 : 16'd0;
            lo_cnt <= (!flash_we_n) ? lo_cnt + 16'd1 : 16'd0;
        end
    end

    a_r4_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> (!flash_ce_n && flash_dq_oe));

    a_r4_bus_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

    a_r4_hold_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> ($stable(flash_addr) && $stable(flash_dq_out) && !flash_ce_n));

    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (lo_cnt == 16'(WE_LOW_CLKS)));

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));

    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> (!flash_dq_oe && !flash_ce_n));

    a_r6_locked_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(locked) |-> ($past(!flash_oe_n) || $rose(busy)));

    a_r7_gap_between: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flash_ce_n && hi_cnt != 16'd0) |-> (hi_cnt == 16'(GAP_CLKS)));

    a_r7_gap_final: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hi_cnt == 16'(GAP_CLKS)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flash_ce_n && !busy));
endmodule

bind pwd_unlock_seq pwd_seq_checker #(
    .CLK_HZ      (CLK_HZ),
    .ADDR_W      (ADDR_W),
    .WE_LOW_CLKS (WE_LOW_CLKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .locked       (locked),
    .flash_addr   (flash_addr),
    .flash_dq_out (flash_dq_out),
    .flash_dq_oe  (flash_dq_oe),
    .flash_ce_n   (flash_ce_n),
    .flash_we_n   (flash_we_n),
    .flash_oe_n   (flash_oe_n)
);

// File: tb/pwd_unlock_seq_test.sv
module pwd_unlock_seq_test;
    localparam longint     HZ     = 1_700_000;
    localparam int         AW     = 12;
    localparam int         WLOW   = 2;
    localparam int         RDC    = 2;
    localparam logic [7:0] CMD    = 8'hC3;
    localparam int         GAP_EXP  = int'((HZ * 2 + 999_999) / 1_000_000);
    localparam int         BUSY_EXP = 4 * (4 * (WLOW + 2) + RDC + GAP_EXP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   password = '0;
    logic          busy, done, locked, dq_oe, ce_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [15:0]   dq_out, dq_in;
    logic [15:0]   resp [4];

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    assign dq_in = (!oe_n) ? resp[addr[1:0]] : 16'h5A5A;

    pwd_unlock_seq #(
        .CLK_HZ(HZ), .ADDR_W(AW), .WE_LOW_CLKS(WLOW), .RD_CLKS(RDC), .CMD_CODE(CMD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .password(password),
        .busy(busy), .done(done), .locked(locked),
        .flash_addr(addr), .flash_dq_out(dq_out), .flash_dq_oe(dq_oe),
        .flash_dq_in(dq_in), .flash_ce_n(ce_n), .flash_we_n(we_n), .flash_oe_n(oe_n)
    );

    // Monitor state
    logic [AW-1:0] wa [32];
    logic [15:0]   wd [32];
    logic [AW-1:0] ra [8];
    int            gaps [8];
    int nwr, nrd, ngap, rd_cyc, final_gap, done_cnt, busy_cyc, unsteady, overlap, hi_run;
    logic          prev_we = 1'b1, prev_ce = 1'b1, prev_oe = 1'b1;
    logic [AW-1:0] lo_a;
    logic [15:0]   lo_d;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles == 150_000) begin
            check(1'b0, "watchdog", cycles, 0);
            finish_run();
        end
        if (rst_n) begin
            if (prev_we && !we_n) begin
                lo_a = addr;
                lo_d = dq_out;
            end
            if (!prev_we && we_n) begin
                if (nwr < 32) begin
                    wa[nwr] = addr;
                    wd[nwr] = dq_out;
                end
                if (addr != lo_a || dq_out != lo_d || ce_n || !dq_oe) unsteady++;
                nwr++;
            end
            if (!we_n && !oe_n) overlap++;
            if (!oe_n) begin
                rd_cyc++;
                if (dq_oe || ce_n) unsteady++;
            end
            if (prev_oe && !oe_n) begin
                if (nrd < 8) ra[nrd] = addr;
                nrd++;
            end
            if (prev_ce && !ce_n && hi_run > 0) begin
                if (ngap < 8) gaps[ngap] = hi_run;
                ngap++;
            end
            if (done) begin
                final_gap = hi_run;
                done_cnt++;
            end
            if (busy) busy_cyc++;
            hi_run = (busy && ce_n) ? hi_run + 1 : 0;
        end
        prev_we = we_n;
        prev_ce = ce_n;
        prev_oe = oe_n;
    end

    task automatic run(input logic [63:0] pw, input logic [15:0] r0, input logic [15:0] r1,
                       input logic [15:0] r2, input logic [15:0] r3,
                       input bit exp_lock, input bit stray_start);
        int waited;
        nwr = 0; nrd = 0; ngap = 0; rd_cyc = 0; final_gap = -1; done_cnt = 0;
        busy_cyc = 0; unsteady = 0; overlap = 0; hi_run = 0;
        resp[0] = r0; resp[1] = r1; resp[2] = r2; resp[3] = r3;
        @(negedge clk);
        password = pw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (done_cnt == 0 && waited < 2000) begin
            @(negedge clk);
            waited++;
            if (stray_start && waited == 30) start = 1'b1;
            if (stray_start && waited == 31) start = 1'b0;
        end
        repeat (4) @(negedge clk);
        check(nwr == 16, "R9 write count", nwr, 16);
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] ea;
                logic [15:0]   ed;
                int n;
                n = k * 4 + s;
                case (s)
                    0: begin ea = AW'(12'h555); ed = 16'h00AA; end
                    1: begin ea = AW'(12'h2AA); ed = 16'h0055; end
                    2: begin ea = AW'(12'h555); ed = {8'h00, CMD}; end
                    default: begin ea = AW'(k); ed = pw[16*k +: 16]; end
                endcase
                if (s == 3) check(wa[n] == ea && wd[n] == ed, "R3 piece write",
                                  {wa[n], wd[n]}, {ea, ed});
                else        check(wa[n] == ea && wd[n] == ed, "R2 unlock/command write",
                                  {wa[n], wd[n]}, {ea, ed});
            end
            check(ra[k] == AW'(k), "R5 read address", ra[k], k);
        end
        check(unsteady == 0, "R4 bus steady across write and read", unsteady, 0);
        check(overlap == 0, "R5 we/oe overlap", overlap, 0);
        check(nrd == 4 && rd_cyc == 4 * RDC, "R5 read cycles", rd_cyc, 4 * RDC);
        check(ngap == 3, "R7 gap count", ngap, 3);
        for (int g = 0; g < 3; g++) check(gaps[g] == GAP_EXP, "R7 gap length", gaps[g], GAP_EXP);
        check(final_gap == GAP_EXP, "R7 final gap", final_gap, GAP_EXP);
        check(done_cnt == 1, "R8 done pulses", done_cnt, 1);
        check(busy_cyc == BUSY_EXP, "R8 busy length", busy_cyc, BUSY_EXP);
        check(locked == exp_lock, "R6 locked flag", locked, exp_lock);
        check(!busy && ce_n, "R9 idle after done", busy, 0);
    endtask

    initial begin
        resp[0] = '0; resp[1] = '0; resp[2] = '0; resp[3] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        check(ce_n && we_n && oe_n && !busy && !done && !locked && !dq_oe,
              "R1 reset state", {ce_n, we_n, oe_n, busy, done, locked, dq_oe}, 7'b1110000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ce_n && we_n && oe_n && !busy && !done && !locked && !dq_oe,
              "R1 idle after reset", {ce_n, we_n, oe_n, busy, done, locked, dq_oe}, 7'b1110000);

        // R2/R3 sweep of password patterns, device unlocked
        run(64'h0123_4567_89AB_CDEF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
        run(64'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
        run(64'hFFFF_FFFF_FFFF_FFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            logic [63:0] p;
            p = {16'(16'h1 << i), 16'(~(16'h1 << i)), 16'(i * 16'h1111), 16'(16'h8000 >> i)};
            run(p, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
        end

        // R6: lock responses
        run(64'hDEAD_BEEF_CAFE_F00D, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
        run(64'h1111_2222_3333_4444, 16'h0000, 16'h0000, 16'h00FF, 16'h0000, 1'b1, 1'b0);
        run(64'h1111_2222_3333_4444, 16'hFF00, 16'hFF00, 16'hFF00, 16'hFF00, 1'b0, 1'b0);
        run(64'hA5A5_5A5A_0F0F_F0F0, 16'h12FE, 16'h0000, 16'h0000, 16'h00FF, 1'b1, 1'b0);
        // R6: cleared by next start
        run(64'h0F0F_0F0F_0F0F_0F0F, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);

        // R9: start pulse in mid-transfer ignored
        run(64'h7654_3210_FEDC_BA98, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1);
        repeat (10) @(negedge clk);
        check(!busy && nwr == 16, "R9 no second transfer", nwr, 16);

        finish_run();
    end
endmodule